// File: doc/BRIEF.md
# Event-Triggered Multi-Axis Position Capture

This block keeps five free-running 32-bit position counters, four for the axes and one auxiliary. Each counter moves by one per cycle under an up/down count strobe that a quadrature front end outside the block supplies. Alongside the counters sits a shared bank of ten capture slots. Each slot can be pointed at any counter and armed by any of five event detectors. One event can therefore latch several axes in the same cycle, for example when a touch probe fires.

Each event detector belongs to one encoder interface. It first synchronizes seven digital inputs for that interface: three general-purpose line inputs, a home switch, the two travel limits and the index mark. It then looks the resulting 7-bit pattern up in a programmable 128-entry truth table. Any single-input polarity and any combination of levels (such as "home low while index high") can be expressed this way. A capture is triggered when the table output turns from 0 to 1. A host register port programs the tables and the slot mapping, and reads counters, captured values and the per-slot valid flags.

Top module: `pos_capture_bank`

## Requirements
- R1: Each of the five counters resets to 0. On a cycle where its `step` bit is 1, it increments when the matching `dir_up` bit is 1 and decrements otherwise, wrapping modulo 2^32. With `step` at 0 it holds.
- R2: A host read of address 0x00+n (n = 0..4) returns counter n.
- R3: The truth table of event e (e = 0..4) is held in four 32-bit words at address 0x40+4e+w (w = 0..3). Table entry i sits in word i/32, bit i%32. The table is indexed by `evt_raw[7e+6 : 7e]`, with bit 3 taken as home and bit 6 as index. Written words read back unchanged, and all tables reset to 0.
- R4: Event e fires exactly when its table output, looked up from the inputs after a two-flop synchronizer, changes from 0 to 1. No level or falling change fires.
- R5: The configuration of slot k (k = 0..9) is at address 0x10+k, with bits [2:0] selecting the counter, bits [6:4] selecting the event and bit 8 enabling the slot. It reads back in the same layout with the other bits 0. An event select above 4 never triggers, and a counter select above 4 captures the value 0.
- R6: An enabled slot whose selected event fires latches the selected counter's value on the clock cycle after the firing is detected, and sets its valid flag.
- R7: One firing event latches every enabled slot that selects it in the same cycle, each from its own selected counter.
- R8: A slot whose enable bit is 0 never latches and never sets its valid flag.
- R9: While a slot's valid flag is set, further firings of its event leave its data and flag unchanged.
- R10: Address 0x20+k returns slot k's captured value and clears its valid flag. Address 0x30 returns the ten valid flags in bits [9:0], with bit k belonging to slot k, and reading it clears nothing.
- R11: Read data appears on `host_rdata` from the clock edge that samples `host_rd` and holds until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 5 | Per-counter count strobe |
| dir_up | input | 5 | Per-counter direction, 1 = up |
| evt_raw | input | 35 | Seven raw event inputs per interface, interface e at bits [7e+6:7e] |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |

## Verification
The hardest situation to reach from the ports is a second rising edge of a slot's event that arrives while the slot still holds an unread value. The counters also have to have moved in between, so that an overwrite would show. The stimulus reaches it by firing the event, stepping the counters, dropping and raising the same input pattern again, and only then reading the slots. A second corner is the exact 0-to-1 rule of the truth table. An arithmetic table pattern is walked through all 128 input codes, in an odd-stride order that produces both rising and non-rising transitions.

// File: rtl/pos_cap_pkg.sv
package pos_cap_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 3;

  // host register regions
  localparam logic [ADDR_W-1:0] A_CTR  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h10;
  localparam logic [ADDR_W-1:0] A_CAP  = 8'h20;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] A_LUT  = 8'h40;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] evt;
    logic [SEL_W-1:0] ctr;
  } slot_cfg_t;

endpackage

// File: rtl/pos_counter.sv
module pos_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         up,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    if (up) cnt_n = cnt_q + W'(1);
    else    cnt_n = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_n;
  end

  assign count = cnt_q;

endmodule

// File: rtl/event_table.sv
module event_table #(
  parameter int IN_W   = 7,
  parameter int WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IN_W-1:0]              raw,
  input  logic                         wr_en,
  input  logic [$clog2(((1<<IN_W)+WORD_W-1)/WORD_W)-1:0] wr_word,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [(1<<IN_W)-1:0]         table_bits,
  output logic                         fire
);

  localparam int DEPTH  = 1 << IN_W;

  logic [DEPTH-1:0] tbl_q, tbl_n;
  logic [IN_W-1:0]  sync1_q, sync2_q;
  logic             hit_prev_q;
  logic             fire_q;
  logic             hit_now;
  logic             rise;

  // table word update
  always_comb begin
    tbl_n = tbl_q;
    tbl_n[wr_word*WORD_W +: WORD_W] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tbl_q <= '0;
    else if (wr_en) tbl_q <= tbl_n;
  end

  // two-stage input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
    end
  end

  // lookup and rising-edge detection
  always_comb begin
    hit_now = tbl_q[sync2_q];
    rise    = hit_now & ~hit_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_prev_q <= 1'b0;
      fire_q     <= 1'b0;
    end else begin
      hit_prev_q <= hit_now;
      fire_q     <= rise;
    end
  end

  assign table_bits = tbl_q;
  assign fire       = fire_q;

endmodule

// File: rtl/capture_slot.sv
module capture_slot
  import pos_cap_pkg::*;
#(
  parameter int W       = 32,
  parameter int NUM_CTR = 5,
  parameter int NUM_EVT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  slot_cfg_t          cfg,
  input  logic [NUM_EVT-1:0] fire_vec,
  input  logic [NUM_CTR*W-1:0] ctr_flat,
  input  logic               rd_clr,
  output logic [W-1:0]       data,
  output logic               valid
);

  logic         sel_fire;
  logic [W-1:0] sel_val;
  logic         take;
  logic [W-1:0] data_q;
  logic         valid_q, valid_n;

  // event and counter selection
  always_comb begin
    sel_fire = 1'b0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (cfg.evt == SEL_W'(e)) sel_fire = fire_vec[e];
    end
  end

  always_comb begin
    sel_val = '0;
    for (int c = 0; c < NUM_CTR; c++) begin
      if (cfg.ctr == SEL_W'(c)) sel_val = ctr_flat[c*W +: W];
    end
  end

  // latch only when armed and empty
  always_comb begin
    take    = cfg.en & sel_fire & ~valid_q;
    valid_n = valid_q;
    if (take)        valid_n = 1'b1;
    else if (rd_clr) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (take) data_q <= sel_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  assign data  = data_q;
  assign valid = valid_q;

endmodule

// File: rtl/pos_capture_bank.sv
module pos_capture_bank
  import pos_cap_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int NUM_CTR = 5,
  parameter int NUM_EVT = 5,
  parameter int EVT_IN  = 7,
  parameter int NUM_CAP = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CTR-1:0]        step,
  input  logic [NUM_CTR-1:0]        dir_up,
  input  logic [NUM_EVT*EVT_IN-1:0] evt_raw,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [DATA_W-1:0]         host_wdata,
  output logic [DATA_W-1:0]         host_rdata
);

  localparam int DEPTH   = 1 << EVT_IN;
  localparam int NWORDS  = (DEPTH + DATA_W - 1) / DATA_W;
  localparam int WSEL_W  = $clog2(NWORDS);
  localparam int LUT_SPAN = NUM_EVT * NWORDS;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  // counters
  logic [NUM_CTR*CTR_W-1:0] ctr_flat;

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    pos_counter #(.W(CTR_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_ni),
      .step  (step[n]),
      .up    (dir_up[n]),
      .count (ctr_flat[n*CTR_W +: CTR_W])
    );
  end

  // truth-table address decode
  logic [ADDR_W-1:0] lut_off;
  logic              lut_hit;
  logic [WSEL_W-1:0] lut_word;

  always_comb begin
    lut_off  = host_addr - A_LUT;
    lut_hit  = (host_addr >= A_LUT) && (lut_off < ADDR_W'(LUT_SPAN));
    lut_word = lut_off[WSEL_W-1:0];
  end

  // event detectors
  logic [NUM_EVT-1:0] evt_fire;
  logic [DEPTH-1:0]   tbl_bits [NUM_EVT];

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    logic tbl_wr;
    assign tbl_wr = host_wr & lut_hit & ((lut_off >> WSEL_W) == ADDR_W'(e));

    event_table #(.IN_W(EVT_IN), .WORD_W(DATA_W)) u_evt (
      .clk        (clk),
      .rst_n      (rst_ni),
      .raw        (evt_raw[e*EVT_IN +: EVT_IN]),
      .wr_en      (tbl_wr),
      .wr_word    (lut_word),
      .wr_data    (host_wdata),
      .table_bits (tbl_bits[e]),
      .fire       (evt_fire[e])
    );
  end

  // capture slots and their configuration
  slot_cfg_t            cfg_q [NUM_CAP];
  logic [NUM_CAP-1:0]   cap_valid;
  logic [NUM_CAP-1:0]   cap_en;
  logic [CTR_W-1:0]     cap_data [NUM_CAP];
  logic [NUM_CAP*CTR_W-1:0] cap_flat;

  for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap
    logic      cfg_wr;
    slot_cfg_t cfg_n;
    logic      rd_clr;

    always_comb begin
      cfg_wr    = host_wr && (host_addr == A_CFG + ADDR_W'(k));
      cfg_n.en  = host_wdata[8];
      cfg_n.evt = host_wdata[4 +: SEL_W];
      cfg_n.ctr = host_wdata[0 +: SEL_W];
      rd_clr    = host_rd && (host_addr == A_CAP + ADDR_W'(k));
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)     cfg_q[k] <= '0;
      else if (cfg_wr) cfg_q[k] <= cfg_n;
    end

    capture_slot #(
      .W       (CTR_W),
      .NUM_CTR (NUM_CTR),
      .NUM_EVT (NUM_EVT)
    ) u_slot (
      .clk      (clk),
      .rst_n    (rst_ni),
      .cfg      (cfg_q[k]),
      .fire_vec (evt_fire),
      .ctr_flat (ctr_flat),
      .rd_clr   (rd_clr),
      .data     (cap_data[k]),
      .valid    (cap_valid[k])
    );

    assign cap_en[k] = cfg_q[k].en;
    assign cap_flat[k*CTR_W +: CTR_W] = cap_data[k];
  end

  // read multiplexer
  logic [DATA_W-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (host_addr == A_CTR + ADDR_W'(n)) rd_n = DATA_W'(ctr_flat[n*CTR_W +: CTR_W]);
    end
    for (int k = 0; k < NUM_CAP; k++) begin
      if (host_addr == A_CFG + ADDR_W'(k))
        rd_n = DATA_W'({cfg_q[k].en, 1'b0, cfg_q[k].evt, 1'b0, cfg_q[k].ctr});
      if (host_addr == A_CAP + ADDR_W'(k)) rd_n = DATA_W'(cap_data[k]);
    end
    if (host_addr == A_STAT) rd_n = DATA_W'(cap_valid);
    if (lut_hit) begin
      for (int e = 0; e < NUM_EVT; e++) begin
        if ((lut_off >> WSEL_W) == ADDR_W'(e))
          rd_n = tbl_bits[e][lut_word*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_n;
  end

endmodule

// File: rtl/pos_capture_chk.sv
module pos_capture_chk
  import pos_cap_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int NUM_CTR = 5,
  parameter int NUM_EVT = 5,
  parameter int NUM_CAP = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CTR-1:0]       step,
  input logic [NUM_CTR-1:0]       dir_up,
  input logic                     host_rd,
  input logic [ADDR_W-1:0]        host_addr,
  input logic [NUM_CTR*CTR_W-1:0] ctr_flat,
  input logic [NUM_EVT-1:0]       evt_fire,
  input logic [NUM_CAP-1:0]       cap_en,
  input logic [NUM_CAP-1:0]       cap_valid,
  input logic [NUM_CAP*CTR_W-1:0] cap_flat
);

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr_chk
    // R1
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step[n] |=> (ctr_flat[n*CTR_W +: CTR_W] ==
                   ($past(dir_up[n]) ? $past(ctr_flat[n*CTR_W +: CTR_W]) + CTR_W'(1)
                                     : $past(ctr_flat[n*CTR_W +: CTR_W]) - CTR_W'(1))));
    // R1
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step[n] |=> $stable(ctr_flat[n*CTR_W +: CTR_W]));
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt_chk
    // R4
    fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_fire[e] |=> !evt_fire[e]);
  end

  for (genvar k = 0; k < NUM_CAP; k++) begin : g_cap_chk
    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid[k] && !(host_rd && host_addr == A_CAP + ADDR_W'(k)))
      |=> (cap_valid[k] && $stable(cap_flat[k*CTR_W +: CTR_W])));
    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid[k] && host_rd && host_addr == A_CAP + ADDR_W'(k)) |=> !cap_valid[k]);
    // R8
    cap_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_valid[k]) |-> $past(cap_en[k]));
  end

endmodule

bind pos_capture_bank pos_capture_chk #(
  .CTR_W   (CTR_W),
  .NUM_CTR (NUM_CTR),
  .NUM_EVT (NUM_EVT),
  .NUM_CAP (NUM_CAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .step      (step),
  .dir_up    (dir_up),
  .host_rd   (host_rd),
  .host_addr (host_addr),
  .ctr_flat  (ctr_flat),
  .evt_fire  (evt_fire),
  .cap_en    (cap_en),
  .cap_valid (cap_valid),
  .cap_flat  (cap_flat)
);

// File: tb/pos_capture_bank_tb.sv
module pos_capture_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic [4:0]  step;
  logic [4:0]  dir_up;
  logic [34:0] evt_raw;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] exp_ctr [5];
  logic        done = 1'b0;

  pos_capture_bank u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .dir_up     (dir_up),
    .evt_raw    (evt_raw),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic do_steps(input logic [4:0] m, input logic [4:0] u, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step = m; dir_up = u;
      for (int c = 0; c < 5; c++)
        if (m[c]) exp_ctr[c] = u[c] ? exp_ctr[c] + 32'd1 : exp_ctr[c] - 32'd1;
    end
    @(negedge clk);
    step = '0;
  endtask

  function automatic logic sweep_bit(input int i);
    return 1'(((i * 29 + 7) >> 2) & 1);
  endfunction

  function automatic logic probe_bit(input int i);
    // home (bit 3) low and index (bit 6) high
    return (((i >> 3) & 1) == 0) && (((i >> 6) & 1) == 1);
  endfunction

  function automatic logic [31:0] cfg_word(input int en, input int ev, input int ct);
    return (32'(en) << 8) | (32'(ev) << 4) | 32'(ct);
  endfunction

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] wv;
    logic [31:0] old_cap [5];
    logic        prev_b, cur_b, exp_fire;

    step = '0; dir_up = '0; evt_raw = '0;
    host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    for (int c = 0; c < 5; c++) exp_ctr[c] = '0;
    rst_n = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);

    // reset state
    check(host_rdata, 32'h0, "R11 reset rdata");
    for (int c = 0; c < 5; c++) begin
      host_read(8'h00 + 8'(c), rd);
      check(rd, 32'h0, "R1 reset counter");
    end
    host_read(8'h30, rd);
    check(rd, 32'h0, "R10 reset status");

    // counting, including a downward wrap on counter 4
    do_steps(5'b01111, 5'b01111, 3);
    do_steps(5'b00110, 5'b00110, 4);
    do_steps(5'b10001, 5'b00000, 2);
    wait_cyc(1);
    for (int c = 0; c < 5; c++) begin
      host_read(8'h00 + 8'(c), rd);
      check(rd, exp_ctr[c], "R1 R2 counter value");
    end

    // configuration readback
    for (int k = 0; k < 10; k++)
      host_write(8'h10 + 8'(k), 32'hFFFF_FE00 | cfg_word(k < 8, (k * 3) % 8, (k * 5) % 8));
    for (int k = 0; k < 10; k++) begin
      host_read(8'h10 + 8'(k), rd);
      check(rd, cfg_word(k < 8, (k * 3) % 8, (k * 5) % 8), "R5 config readback");
    end
    for (int k = 0; k < 10; k++) host_write(8'h10 + 8'(k), 32'h0);

    // truth-table readback
    for (int w = 0; w < 20; w++) host_write(8'h40 + 8'(w), 32'h9E37_79B9 * 32'(w + 1));
    for (int w = 0; w < 20; w++) begin
      host_read(8'h40 + 8'(w), rd);
      check(rd, 32'h9E37_79B9 * 32'(w + 1), "R3 table readback");
    end
    for (int w = 0; w < 20; w++) host_write(8'h40 + 8'(w), 32'h0);
    wait_cyc(5);
    host_read(8'h30, rd);
    check(rd, 32'h0, "R8 no capture while disabled");

    // probe event on interface 1: home low, index high
    for (int w = 0; w < 4; w++) begin
      wv = '0;
      for (int b = 0; b < 32; b++) wv[b] = probe_bit(w * 32 + b);
      host_write(8'h44 + 8'(w), wv);
    end
    for (int k = 0; k < 5; k++) host_write(8'h10 + 8'(k), cfg_word(1, 1, k));
    host_write(8'h15, cfg_word(0, 1, 0));   // disabled slot
    host_write(8'h16, cfg_word(1, 7, 0));   // event select out of range
    wait_cyc(3);
    @(negedge clk); evt_raw[7 +: 7] = 7'b100_1000;  // home high: no hit
    wait_cyc(6);
    host_read(8'h30, rd);
    check(rd, 32'h0, "R4 combination not met");
    @(negedge clk); evt_raw[7 +: 7] = 7'b100_0000;  // home low, index high
    wait_cyc(6);
    host_read(8'h30, rd);
    check(rd, 32'h0000_001F, "R7 R8 R5 multi-slot status");
    for (int k = 0; k < 5; k++) old_cap[k] = exp_ctr[k];

    // second edge while slots still hold data
    @(negedge clk); evt_raw[7 +: 7] = 7'b000_0000;
    wait_cyc(6);
    do_steps(5'b11111, 5'b10101, 5);
    @(negedge clk); evt_raw[7 +: 7] = 7'b100_0000;
    wait_cyc(6);
    host_read(8'h30, rd);
    check(rd, 32'h0000_001F, "R9 flags held");
    for (int k = 0; k < 5; k++) begin
      host_read(8'h20 + 8'(k), rd);
      check(rd, old_cap[k], "R6 R9 captured value kept");
    end
    host_read(8'h30, rd);
    check(rd, 32'h0, "R10 read clears flags");

    // fresh edge after clearing captures the new counts
    @(negedge clk); evt_raw[7 +: 7] = 7'b000_0000;
    wait_cyc(6);
    @(negedge clk); evt_raw[7 +: 7] = 7'b110_0101;
    wait_cyc(6);
    for (int k = 0; k < 5; k++) begin
      host_read(8'h20 + 8'(k), rd);
      check(rd, exp_ctr[k], "R6 R7 recapture");
    end
    host_read(8'h31, rd);
    check(rd, 32'h0, "R11 unmapped read");

    // full sweep of interface 2 table
    for (int k = 0; k < 10; k++) host_write(8'h10 + 8'(k), 32'h0);
    for (int w = 0; w < 4; w++) begin
      wv = '0;
      for (int b = 0; b < 32; b++) wv[b] = sweep_bit(w * 32 + b);
      host_write(8'h48 + 8'(w), wv);
    end
    wait_cyc(6);
    host_write(8'h19, cfg_word(1, 2, 2));
    host_write(8'h18, cfg_word(1, 2, 7));   // counter select out of range
    host_write(8'h16, cfg_word(1, 7, 2));
    prev_b = sweep_bit(0);
    for (int j = 1; j <= 128; j++) begin
      int idx;
      idx = (j * 45) % 128;
      cur_b = sweep_bit(idx);
      exp_fire = cur_b & ~prev_b;
      @(negedge clk); evt_raw[14 +: 7] = 7'(idx);
      wait_cyc(5);
      host_read(8'h30, rd);
      check(rd, exp_fire ? 32'h0000_0300 : 32'h0, "R4 sweep status");
      if (exp_fire) begin
        host_read(8'h29, rd);
        check(rd, exp_ctr[2], "R6 sweep capture");
        host_read(8'h28, rd);
        check(rd, 32'h0, "R5 counter select beyond range");
      end
      prev_b = cur_b;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule